// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage In-Order Pipeline

This block turns faults seen inside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) into a precise trap. Three stages can report a fault:
- decode flags an undefined opcode;
- execute flags an arithmetic overflow;
- memory flags an access fault.

Each reporting stage also supplies a valid bit, which is low for a bubble, and the program counter that travelled with its instruction. The faulting instruction is therefore identified by its own address and not by the fetch address, which has already moved on.

When one or more stages report in a cycle, the controller keeps only the oldest report, which comes from the deepest stage. In the next cycle it does all of the following:
- drives a per-stage kill mask covering the faulting instruction and every younger one;
- pulses a redirect to a handler address selected by the fault kind;
- updates the saved-PC register and the cause register.

The handling order is fixed: detect, kill, record the kind, record the PC, redirect.

The kill mask refers to the pipeline contents in the cycle it is driven. By then the faulting instruction has advanced one stage. The mask therefore runs from fetch up to one stage past the stage that reported the fault. Stage bits are numbered fetch=0, decode=1, execute=2, memory=3, writeback=4. A report from a stage that is being killed in the current cycle belongs to an instruction that is already squashed, and it is dropped. A report from a deeper, unkilled stage belongs to an older instruction. It is accepted and replaces the earlier record.

Every pin is a plain control or status signal. The fault reports arrive at most once per cycle and cannot be held back, so there is no valid/ready handshake and no back-pressure.

Top module: `trap_unit`

## Requirements
- R1: During and right after reset, the kill mask is 0, redirect is low, and the saved PC and the cause word are 0.
- R2: An accepted decode fault gives, one cycle later: a redirect pulse to 0xC0000000, saved PC equal to the decode PC, cause word 0x28 (code 10 in bits 6:2), and kill mask 5'b00111.
- R3: An accepted execute overflow gives, one cycle later: a redirect to 0xC0000020, saved PC equal to the execute PC, cause word 0x30 (code 12, so bit 5 is set), and kill mask 5'b01111.
- R4: An accepted memory fault gives, one cycle later: a redirect to 0xC0000040, saved PC equal to the memory PC, cause word 0x10 (code 4), and kill mask 5'b11111.
- R5: When several stages report in the same cycle, memory beats execute and execute beats decode. The younger reports leave no trace.
- R6: A fault flag whose stage valid bit is low is ignored.
- R7: A fault flag from a stage whose bit in the current kill mask is set is ignored. A report from a deeper stage that is not being killed is still accepted and overwrites the saved PC and cause.
- R8: Redirect is high for exactly one cycle per accepted fault. The saved PC and cause keep their values until the next accepted fault.
- R9: In a cycle that follows one with no accepted fault, redirect is low and the kill mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| id_vld_i | input | 1 | Decode stage holds a real instruction |
| id_undef_i | input | 1 | Decode found an undefined opcode |
| id_pc_i | input | 32 | PC of the decode-stage instruction |
| ex_vld_i | input | 1 | Execute stage holds a real instruction |
| ex_ovf_i | input | 1 | Execute produced an arithmetic overflow |
| ex_pc_i | input | 32 | PC of the execute-stage instruction |
| mem_vld_i | input | 1 | Memory stage holds a real instruction |
| mem_fault_i | input | 1 | Memory access faulted |
| mem_pc_i | input | 32 | PC of the memory-stage instruction |
| flush_o | output | 5 | Kill mask, bit 0 = fetch through bit 4 = writeback |
| redirect_o | output | 1 | One-cycle pulse to load the handler address |
| redirect_pc_o | output | 32 | Handler address |
| epc_o | output | 32 | PC of the last trapped instruction |
| cause_o | output | 32 | Cause word, code in bits 6:2 |

## Verification
Each fault kind is first raised alone so that its vector, code, saved PC and mask width are told apart. Simultaneous reports in pairs and in all three stages then show that age, and not arrival order, decides the winner. Reports with the valid bit low, and reports in the cycle right after a trap, separate a dropped squashed instruction from an older one that must still win. Idle cycles between traps show that the record holds and the redirect does not repeat.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NUM_STG = 5;
  localparam int CHK_LO  = 1;
  localparam int CHK_HI  = 3;
  localparam int NUM_CHK = CHK_HI - CHK_LO + 1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ID   = 2'd1,
    SRC_EX   = 2'd2,
    SRC_MEM  = 2'd3
  } trap_src_e;
endpackage

// File: rtl/trap_pick.sv
module trap_pick
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CHK_HI:CHK_LO]    raise_i,
  input  logic [NUM_STG-1:0]      squash_i,
  input  logic [NUM_CHK*XLEN-1:0] pc_bus_i,
  output logic                    take_o,
  output trap_src_e               src_o,
  output logic [XLEN-1:0]         pc_o
);
  logic [CHK_HI:CHK_LO] live;

  for (genvar s = CHK_LO; s <= CHK_HI; s++) begin : g_live
    assign live[s] = raise_i[s] & ~squash_i[s];
  end

  // deeper stage scanned last, so the oldest instruction wins
  always_comb begin
    take_o = 1'b0;
    src_o  = SRC_NONE;
    pc_o   = '0;
    for (int s = CHK_LO; s <= CHK_HI; s++) begin
      if (live[s]) begin
        take_o = 1'b1;
        src_o  = trap_src_e'(2'(s));
        pc_o   = pc_bus_i[(s-CHK_LO)*XLEN +: XLEN];
      end
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter int              VEC_STRIDE = 32,
  parameter int              CODE_W     = 5,
  parameter int              CAUSE_LSB  = 2,
  parameter int              CODE_UNDEF = 10,
  parameter int              CODE_OVF   = 12,
  parameter int              CODE_MEM   = 4
) (
  input  trap_src_e       src_i,
  output logic [XLEN-1:0] vec_o,
  output logic [XLEN-1:0] cause_o
);
  logic [CODE_W-1:0] code;
  int unsigned       slot;

  always_comb begin
    unique case (src_i)
      SRC_ID:  begin code = CODE_W'(CODE_UNDEF); slot = 0; end
      SRC_EX:  begin code = CODE_W'(CODE_OVF);   slot = 1; end
      SRC_MEM: begin code = CODE_W'(CODE_MEM);   slot = 2; end
      default: begin code = '0;                  slot = 0; end
    endcase
  end

  assign vec_o = VEC_BASE + XLEN'(slot * VEC_STRIDE);

  always_comb begin
    cause_o = '0;
    cause_o[CAUSE_LSB +: CODE_W] = code;
  end
endmodule

// File: rtl/trap_record.sv
module trap_record
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  trap_src_e          src_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    vec_i,
  input  logic [XLEN-1:0]    cause_i,
  output logic [NUM_STG-1:0] flush_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    cause_o
);
  logic [NUM_STG-1:0] kill_mask;

  // faulting instruction sits one stage deeper next cycle
  for (genvar k = 0; k < NUM_STG; k++) begin : g_mask
    assign kill_mask[k] = (k <= int'(src_i) + 1);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flush_o       <= '0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      epc_o         <= '0;
      cause_o       <= '0;
    end else begin
      redirect_o <= take_i;
      flush_o    <= take_i ? kill_mask : '0;
      if (take_i) begin
        redirect_pc_o <= vec_i;
        epc_o         <= pc_i;
        cause_o       <= cause_i;
      end
    end
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter int              VEC_STRIDE = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               id_vld_i,
  input  logic               id_undef_i,
  input  logic [XLEN-1:0]    id_pc_i,
  input  logic               ex_vld_i,
  input  logic               ex_ovf_i,
  input  logic [XLEN-1:0]    ex_pc_i,
  input  logic               mem_vld_i,
  input  logic               mem_fault_i,
  input  logic [XLEN-1:0]    mem_pc_i,
  output logic [NUM_STG-1:0] flush_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    cause_o
);
  logic [CHK_HI:CHK_LO]    raise;
  logic [NUM_CHK*XLEN-1:0] pc_bus;
  logic                    take;
  trap_src_e               src;
  logic [XLEN-1:0]         sel_pc, vec, cause_nxt;

  assign raise  = {mem_vld_i & mem_fault_i, ex_vld_i & ex_ovf_i, id_vld_i & id_undef_i};
  assign pc_bus = {mem_pc_i, ex_pc_i, id_pc_i};

  trap_pick #(.XLEN(XLEN)) u_pick (
    .raise_i (raise),
    .squash_i(flush_o),
    .pc_bus_i(pc_bus),
    .take_o  (take),
    .src_o   (src),
    .pc_o    (sel_pc)
  );

  trap_vector #(.XLEN(XLEN), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_vec (
    .src_i  (src),
    .vec_o  (vec),
    .cause_o(cause_nxt)
  );

  trap_record #(.XLEN(XLEN)) u_rec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .src_i        (src),
    .pc_i         (sel_pc),
    .vec_i        (vec),
    .cause_i      (cause_nxt),
    .flush_o      (flush_o),
    .redirect_o   (redirect_o),
    .redirect_pc_o(redirect_pc_o),
    .epc_o        (epc_o),
    .cause_o      (cause_o)
  );
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            id_vld_i,
  input logic            id_undef_i,
  input logic [XLEN-1:0] id_pc_i,
  input logic            ex_vld_i,
  input logic            ex_ovf_i,
  input logic [XLEN-1:0] ex_pc_i,
  input logic            mem_vld_i,
  input logic            mem_fault_i,
  input logic [XLEN-1:0] mem_pc_i,
  input logic [4:0]      flush_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [XLEN-1:0] epc_o,
  input logic [XLEN-1:0] cause_o
);
  logic id_ok, ex_ok, mem_ok;
  assign id_ok  = id_vld_i && id_undef_i && !flush_o[1];
  assign ex_ok  = ex_vld_i && ex_ovf_i && !flush_o[2];
  assign mem_ok = mem_vld_i && mem_fault_i && !flush_o[3];

  assert_undef_vector_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_ok && !ex_ok && !mem_ok) |=> (redirect_o && redirect_pc_o == 32'hC000_0000 &&
      epc_o == $past(id_pc_i) && flush_o == 5'b00111));

  assert_ovf_vector_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_ok && !mem_ok) |=> (redirect_pc_o == 32'hC000_0020 && cause_o[5] &&
      epc_o == $past(ex_pc_i)));

  assert_mem_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ok |=> (epc_o == $past(mem_pc_i) && cause_o == 32'h10 && flush_o == 5'b11111));

  assert_invalid_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_vld_i && !ex_vld_i && !mem_vld_i) |=> !redirect_o);

  assert_squashed_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o[3] |=> !redirect_o);

  assert_record_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> ($stable(epc_o) && $stable(cause_o)));

  assert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_ok && !ex_ok && !mem_ok) |=> (!redirect_o && flush_o == 5'b0));
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_trap_unit.sv
`timescale 1ns/1ps
module test_trap_unit;
  typedef struct packed {
    logic        red;
    logic [31:0] rpc;
    logic [31:0] epc;
    logic [31:0] cause;
    logic [4:0]  flush;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_vld = 0, id_undef = 0, ex_vld = 0, ex_ovf = 0, mem_vld = 0, mem_fault = 0;
  logic [31:0] id_pc = 0, ex_pc = 0, mem_pc = 0;
  logic [4:0]  flush;
  logic        redirect;
  logic [31:0] redirect_pc, epc, cause;

  int   checks = 0;
  int   fails  = 0;
  exp_t expq[$];
  string tagq[$];

  logic [4:0]  m_flush = 0;
  logic [31:0] m_epc = 0, m_cause = 0;

  always #10 clk = ~clk;

  trap_unit i_trap_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .id_vld_i(id_vld), .id_undef_i(id_undef), .id_pc_i(id_pc),
    .ex_vld_i(ex_vld), .ex_ovf_i(ex_ovf), .ex_pc_i(ex_pc),
    .mem_vld_i(mem_vld), .mem_fault_i(mem_fault), .mem_pc_i(mem_pc),
    .flush_o(flush), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .epc_o(epc), .cause_o(cause)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv, string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // driver: apply one cycle of stage reports and queue the expected result
  task automatic step(string tag, logic iv, logic iu, logic [31:0] ip,
                      logic ev, logic eo, logic [31:0] ep,
                      logic mv, logic mf, logic [31:0] mp);
    int   src;
    logic [31:0] pc;
    exp_t e;
    @(negedge clk);
    id_vld = iv; id_undef = iu; id_pc = ip;
    ex_vld = ev; ex_ovf = eo; ex_pc = ep;
    mem_vld = mv; mem_fault = mf; mem_pc = mp;
    src = 0; pc = 0;
    if (iv && iu && !m_flush[1]) begin src = 1; pc = ip; end
    if (ev && eo && !m_flush[2]) begin src = 2; pc = ep; end
    if (mv && mf && !m_flush[3]) begin src = 3; pc = mp; end
    e = '0;
    if (src != 0) begin
      e.red   = 1'b1;
      e.rpc   = 32'hC000_0000 + 32'((src - 1) * 32);
      m_cause = (src == 1) ? 32'h28 : (src == 2) ? 32'h30 : 32'h10;
      m_epc   = pc;
      m_flush = 5'((1 << (src + 2)) - 1);
    end else begin
      m_flush = 5'b0;
    end
    e.epc = m_epc; e.cause = m_cause; e.flush = m_flush;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: compare after each edge, away from it
  always @(posedge clk) begin
    #5;
    if (expq.size() > 0) begin
      exp_t  e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      check(t, 64'(redirect), 64'(e.red), "redirect");
      if (e.red) check(t, 64'(redirect_pc), 64'(e.rpc), "redirect_pc");
      check(t, 64'(epc), 64'(e.epc), "epc");
      check(t, 64'(cause), 64'(e.cause), "cause");
      check(t, 64'(flush), 64'(e.flush), "flush");
    end
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    check("R1", 64'({flush, redirect}), 64'(0), "flush/redirect");
    check("R1", 64'(epc), 64'(0), "epc");
    check("R1", 64'(cause), 64'(0), "cause");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R9");
    idle("R9");
    step("R2", 1, 1, 32'h0000_1004, 0, 0, 0, 0, 0, 0);
    idle("R8");
    idle("R8");
    step("R3", 0, 0, 0, 1, 1, 32'h0000_2008, 0, 0, 0);
    idle("R8");
    step("R4", 0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_300C);
    idle("R9");
    step("R6", 0, 1, 32'h44, 0, 1, 32'h48, 0, 1, 32'h4C);
    idle("R6");
    step("R5", 1, 1, 32'h5010, 1, 1, 32'h500C, 1, 1, 32'h5008);
    idle("R5");
    step("R5", 1, 1, 32'h6010, 1, 1, 32'h600C, 0, 0, 0);
    idle("R5");
    // R7: report from a killed stage is dropped
    step("R2", 1, 1, 32'h7000, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 1, 32'h7008, 1, 1, 32'h7004, 0, 0, 0);
    idle("R7");
    // R7: older instruction below the kill mask still wins
    step("R2", 1, 1, 32'h8010, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 1, 32'h8018, 1, 1, 32'h8014, 1, 1, 32'h800C);
    step("R7", 1, 1, 32'h8020, 1, 1, 32'h801C, 1, 1, 32'h8018);
    idle("R8");
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule